// File: doc/BRIEF.md
# Protected Alternate-Function Select Register

This block holds the per-line mode choice for one eight-line I/O port. Each line can stay under software GPIO control or be handed to a hardware peripheral. The choice goes out as an 8-bit mode vector to the pad multiplexer. Software reaches the block over a simple 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. Every access completes in the cycle it is presented.

Some lines are marked as protected at build time. A write to a protected select bit only reaches storage when two conditions hold. First, the guard has been opened by writing a 32-bit key to the lock register. Second, the matching bit of the commit-mask register is set. Unprotected bits always take the written value. Lines marked as debug pins come out of reset under hardware control, and all other lines come out of reset under GPIO control. The guard stays open until software writes any non-key value to the lock register.

Default build parameters: `DEBUG_MASK` = 8'h0F and `PROT_MASK` = 8'h1F. Lines 3..0 are debug pins and protected. Line 4 is protected but resets to GPIO control. Lines 7..5 are open.

Top module: `alt_func_select_regs`

## Requirements
- R1: On synchronous reset (`rst_n` low at a clock edge) the following values hold:
  - `pad_mode` equals `DEBUG_MASK` (8'h0F by default).
  - The lock register reads 1 (locked).
  - The commit register reads 0.
- R2: A write to offset 0x420 loads every unprotected bit (`PROT_MASK` bit 0) of `pad_mode` from `reg_wdata[7:0]` on that edge, whatever the lock and commit state.
- R3: On a write to offset 0x420, a protected bit `i` takes `reg_wdata[i]` only if the guard is unlocked and commit bit `i` is 1. Otherwise it keeps its value.
- R4: A read of offset 0x420 returns `pad_mode` in bits [7:0] and zero in bits [31:8]. Write data in bits [31:8] has no effect.
- R5: Writing 32'h1ACCE551 to offset 0x520 unlocks the guard. Writing any other value to that offset locks it. A read of 0x520 returns 32'h0 when unlocked and 32'h1 when locked.
- R6: The commit register at offset 0x524 changes only on a write made while unlocked. It loads `reg_wdata[7:0]`, and reads return it in bits [7:0] with zero in bits [31:8].
- R7: Once unlocked, the guard stays unlocked across reads and writes to any offset other than 0x520. There is no timeout.
- R8: A read of any offset other than 0x420, 0x520 or 0x524 (unaligned offsets included) returns 0. A write there changes no register.
- R9: Reset asserted after the block has been programmed returns `pad_mode`, lock and commit to their R1 values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on and external reset merged upstream) |
| reg_addr | input | 12 | Byte offset within the port's register window |
| reg_we | input | 1 | Write strobe, one access per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, valid in the same cycle |
| pad_mode | output | 8 | Per-line mode to the pad multiplexer, 1 = peripheral, 0 = GPIO |

## Verification
The assertions assume the following about the bus inputs:
- `reg_addr`, `reg_we` and `reg_wdata` are known (no X) whenever reset is released.
- A write is a single-cycle strobe captured on one rising edge.

The bench changes every bus input only on the falling clock edge, so each value is stable across the rising edge that captures it. It raises `reg_we` for exactly one rising edge per write. It holds all inputs at zero during reset, so no property sees undefined values once reset is released.

// File: rtl/afs_pkg.sv
// Package afs_pkg
// Purpose : shared constants for the protected alternate-function select
//           register block (bus widths, register offsets, unlock key).
// Assumes : byte-addressed 4 KiB register window, 32-bit data bus.
package afs_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_SELECT = 12'h420;
    localparam logic [ADDR_W-1:0] OFS_GUARD  = 12'h520;
    localparam logic [ADDR_W-1:0] OFS_COMMIT = 12'h524;

    localparam logic [DATA_W-1:0] GUARD_KEY  = 32'h1ACC_E551;

    // Decoded register target for one bus access.
    typedef enum logic [1:0] {
        TGT_NONE   = 2'd0,
        TGT_SELECT = 2'd1,
        TGT_GUARD  = 2'd2,
        TGT_COMMIT = 2'd3
    } afs_target_e;

endpackage

// File: rtl/afs_guard.sv
// Module afs_guard
// Purpose : single-flag lock. A write of the key opens it, and any other
//           written value closes it. Resets closed.
// Assumes : wr_en is a one-cycle strobe qualified by the address decode.
module afs_guard
    import afs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              locked
);

    // Lock flag update: key opens, anything else closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b1;
        end else if (wr_en) begin
            locked <= (wdata != GUARD_KEY);
        end
    end

    // R5: the key written to the guard opens it on the next cycle.
    p_key_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata == GUARD_KEY) |=> !locked);

    // R5: any non-key value written to the guard closes it.
    p_nonkey_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata != GUARD_KEY) |=> locked);

    // R7: without a guard write the state never moves (no timeout).
    p_guard_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(locked));

endmodule

// File: rtl/afs_commit.sv
// Module afs_commit
// Purpose : per-line commit mask that enables changes to protected select
//           bits. It is writable only while the guard is open, and resets
//           to all zero.
// Assumes : wr_en is a one-cycle strobe qualified by the address decode.
module afs_commit #(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             unlocked,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] mask
);

    // Commit mask update, gated by the guard.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (wr_en && unlocked) begin
            mask <= wdata;
        end
    end

    // R6: while the guard is closed the commit mask cannot change.
    p_commit_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(mask));

    // R6: a write with the guard open loads the mask.
    p_commit_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && unlocked) |=> mask == $past(wdata));

endmodule

// File: rtl/afs_select.sv
// Module afs_select
// Purpose : per-line alternate-function select bits. Open lines take every
//           write. Protected lines take a write only with the guard open
//           and their commit bit set. Debug lines reset to peripheral
//           control.
// Assumes : wr_en is a one-cycle strobe qualified by the address decode.
module afs_select #(
    parameter int               LINES      = 8,
    parameter logic [LINES-1:0] DEBUG_MASK = '0,
    parameter logic [LINES-1:0] PROT_MASK  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             unlocked,
    input  logic [LINES-1:0] commit,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] sel
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        if (PROT_MASK[i]) begin : g_prot
            // Protected bit: write only through the guard and commit bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sel[i] <= DEBUG_MASK[i];
                end else if (wr_en && unlocked && commit[i]) begin
                    sel[i] <= wdata[i];
                end
            end

            // R3: a blocked write leaves the protected bit untouched.
            p_prot_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && !(unlocked && commit[i])) |=> sel[i] == $past(sel[i]));

            // R3: an enabled write reaches the protected bit.
            p_prot_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && unlocked && commit[i]) |=> sel[i] == $past(wdata[i]));
        end else begin : g_open
            // Open bit: every write lands.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sel[i] <= DEBUG_MASK[i];
                end else if (wr_en) begin
                    sel[i] <= wdata[i];
                end
            end

            // R2: open bits follow the written data regardless of the guard.
            p_open_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |=> sel[i] == $past(wdata[i]));
        end

        // R8: without a select write no bit moves.
        p_sel_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> $stable(sel[i]));
    end

endmodule

// File: rtl/alt_func_select_regs.sv
// Module alt_func_select_regs
// Purpose : top of the protected alternate-function select block. It
//           decodes the register bus, steers writes to the guard, commit
//           and select registers, and muxes read data. It drives the
//           per-line mode vector to the pad multiplexer.
// Assumes : one access per cycle, no wait states, combinational read.
//           Reset is synchronous active-low, with power-on and external
//           reset merged upstream.
module alt_func_select_regs
    import afs_pkg::*;
#(
    parameter int               LINES      = 8,
    parameter logic [LINES-1:0] DEBUG_MASK = 8'h0F,
    parameter logic [LINES-1:0] PROT_MASK  = 8'h1F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [LINES-1:0]  pad_mode
);

    localparam int PAD_W = DATA_W - LINES;

    afs_target_e      tgt;
    logic             locked;
    logic [LINES-1:0] commit_mask;

    // Address decode to a register target.
    always_comb begin
        unique case (reg_addr)
            OFS_SELECT: tgt = TGT_SELECT;
            OFS_GUARD:  tgt = TGT_GUARD;
            OFS_COMMIT: tgt = TGT_COMMIT;
            default:    tgt = TGT_NONE;
        endcase
    end

    afs_guard u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_we && tgt == TGT_GUARD),
        .wdata  (reg_wdata),
        .locked (locked)
    );

    afs_commit #(.LINES(LINES)) u_commit (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_we && tgt == TGT_COMMIT),
        .unlocked (!locked),
        .wdata    (reg_wdata[LINES-1:0]),
        .mask     (commit_mask)
    );

    afs_select #(
        .LINES      (LINES),
        .DEBUG_MASK (DEBUG_MASK),
        .PROT_MASK  (PROT_MASK)
    ) u_select (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_we && tgt == TGT_SELECT),
        .unlocked (!locked),
        .commit   (commit_mask),
        .wdata    (reg_wdata[LINES-1:0]),
        .sel      (pad_mode)
    );

    // Read data mux, zero-extended, zero for unmapped offsets.
    always_comb begin
        unique case (tgt)
            TGT_SELECT: reg_rdata = {{PAD_W{1'b0}}, pad_mode};
            TGT_GUARD:  reg_rdata = {{(DATA_W-1){1'b0}}, locked};
            TGT_COMMIT: reg_rdata = {{PAD_W{1'b0}}, commit_mask};
            default:    reg_rdata = '0;
        endcase
    end

    // R8: unmapped offsets read as zero.
    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != OFS_SELECT && reg_addr != OFS_GUARD && reg_addr != OFS_COMMIT)
        |-> reg_rdata == '0);

    // R4: select read-back mirrors the pad mode with the upper bits clear.
    p_sel_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_SELECT) |-> (reg_rdata[LINES-1:0] == pad_mode
                                      && reg_rdata[DATA_W-1:LINES] == '0));

    // R1 / R9: the first cycle after a reset edge shows the default values.
    p_reset_defaults_r9: assert property (@(posedge clk)
        $past(!rst_n) |-> (pad_mode == DEBUG_MASK && locked && commit_mask == '0));

endmodule

// File: tb/sim_alt_func_select_regs.sv
// Bench for alt_func_select_regs: a vector table walked by one loop, then
// directed reset and corner-case tests. Inputs change on the falling edge.
module sim_alt_func_select_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  pad_mode;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;   // 125 MHz

    alt_func_select_regs u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pad_mode  (pad_mode)
    );

    localparam logic [11:0] A_SEL = 12'h420;
    localparam logic [11:0] A_LCK = 12'h520;
    localparam logic [11:0] A_CMT = 12'h524;
    localparam logic [31:0] KEY   = 32'h1ACCE551;

    // Each row: {address, write data, expected pad_mode, expected read-back, req}
    localparam int NV = 15;
    localparam logic [91:0] VECS [NV] = '{
        {A_SEL, 32'h0000_00F0, 8'hEF, 32'h0000_00EF, 8'd2},  // R2 open bits take data, R3 protected hold
        {A_SEL, 32'hFFFF_FF00, 8'h0F, 32'h0000_000F, 8'd4},  // R4 upper write bits ignored
        {A_CMT, 32'h0000_00FF, 8'h0F, 32'h0000_0000, 8'd6},  // R6 commit blocked while locked
        {A_LCK, KEY,           8'h0F, 32'h0000_0000, 8'd5},  // R5 key unlocks
        {A_SEL, 32'h0000_0000, 8'h0F, 32'h0000_000F, 8'd3},  // R3 unlocked but commit clear
        {A_CMT, 32'hFFFF_FF05, 8'h0F, 32'h0000_0005, 8'd6},  // R6 commit loads, upper zero
        {A_SEL, 32'h0000_0000, 8'h0A, 32'h0000_000A, 8'd3},  // R3 committed bits 0,2 clear
        {12'h000, 32'hFFFF_FFFF, 8'h0A, 32'h0000_0000, 8'd8}, // R8 unmapped write/read
        {A_SEL, 32'h0000_00FF, 8'hEF, 32'h0000_00EF, 8'd7},  // R7 guard still open
        {A_LCK, 32'h1234_5678, 8'hEF, 32'h0000_0001, 8'd5},  // R5 non-key locks
        {A_SEL, 32'h0000_0000, 8'h0F, 32'h0000_000F, 8'd3},  // R3 locked: protected hold
        {A_CMT, 32'h0000_0000, 8'h0F, 32'h0000_0005, 8'd6},  // R6 commit frozen when locked
        {A_LCK, KEY,           8'h0F, 32'h0000_0000, 8'd5},  // R5 unlock again
        {A_LCK, 32'h1ACC_E550, 8'h0F, 32'h0000_0001, 8'd5},  // R5 near-key locks
        {12'h421, 32'hFFFF_FFFF, 8'h0F, 32'h0000_0000, 8'd8} // R8 unaligned offset
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        reg_we   = 1'b0;
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        check("R1", "pad_mode after reset", {24'h0, pad_mode}, 32'h0000_000F);
        bus_read(A_SEL, rd); check("R1", "select read", rd, 32'h0000_000F);
        bus_read(A_LCK, rd); check("R1", "lock read", rd, 32'h0000_0001);
        bus_read(A_CMT, rd); check("R1", "commit read", rd, 32'h0000_0000);

        for (int k = 0; k < NV; k++) begin
            logic [91:0] v;
            v = VECS[k];
            bus_write(v[91:80], v[79:48]);
            check($sformatf("R%0d", v[7:0]), $sformatf("vec %0d pad_mode", k),
                  {24'h0, pad_mode}, {24'h0, v[47:40]});
            bus_read(v[91:80], rd);
            check($sformatf("R%0d", v[7:0]), $sformatf("vec %0d readback", k),
                  rd, v[39:8]);
        end

        // R7: guard stays open across other reads and writes
        bus_write(A_LCK, KEY);
        bus_write(12'h7FC, 32'hDEAD_BEEF);
        repeat (50) @(negedge clk);
        bus_read(A_SEL, rd);
        bus_read(A_LCK, rd); check("R7", "guard open after idle and other writes", rd, 32'h0);

        // R3: full commit, program protected line 4 and clear debug lines
        bus_write(A_CMT, 32'h0000_00FF);
        bus_write(A_SEL, 32'h0000_0010);
        check("R3", "protected lines rewritten", {24'h0, pad_mode}, 32'h0000_0010);

        // R9: mid-operation reset restores defaults
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R9", "pad_mode after reset", {24'h0, pad_mode}, 32'h0000_000F);
        bus_read(A_LCK, rd); check("R9", "lock after reset", rd, 32'h0000_0001);
        bus_read(A_CMT, rd); check("R9", "commit after reset", rd, 32'h0000_0000);

        // R8: write to an unmapped offset changes nothing
        bus_write(12'h528, 32'hFFFF_FFFF);
        check("R8", "pad_mode after unmapped write", {24'h0, pad_mode}, 32'h0000_000F);
        bus_read(A_CMT, rd); check("R8", "commit after unmapped write", rd, 32'h0);

        summary();
    end

endmodule